// File: doc/BRIEF.md
# Memory-Side Request Arbiter

This block decides which outstanding request a cache sends next on its memory-side bus. Three producers compete for the slot: the miss queue, the write-back buffer and a prefetch source. Each queue presents its head entry that is ready to go, with entry index, byte address, byte size and, for the write-back buffer, an age tag. A lookup outside the block also presents one candidate from each queue that may collide with the other queue's head: the oldest pending miss that might overlap the write-back head, and a pending write-back that might overlap the miss head. The arbiter tests those candidates for overlap itself, at cache-line granularity.

The arbiter is built around a three-state machine. In IDLE it evaluates its inputs every cycle. When a source wins and no response is waiting for the port, the transition take moves it to OFFER, where the registered grant is driven onto the bus until the bus answers. The transition accept returns it to IDLE and pulses an in-service notice naming the entry, so the owning queue can mark it. The transition refuse moves it to HOLD, where the grant is kept but not driven. The transition retry returns it to OFFER with the same grant. Nothing is re-decided while a grant is pending.

Top module: `memreq_arbiter`

## Requirements
- R1: While reset is low, and in the first cycle after it, `gnt_vld` and `svc_vld` are 0.
- R2: When exactly one of the miss queue and the write-back buffer has a ready head, that head is granted. `gnt_vld` rises one clock after the inputs are presented. `gnt_src` is 1 for a miss, 2 for a write-back and 3 for a prefetch. `gnt_idx` carries the entry index.
- R3: When both heads are ready, the miss head is granted unless the write-back buffer is full with zero entries in service. This applies when no overlapping write-back candidate exists.
- R4: When both heads are ready and the miss is favoured, a valid write-back candidate that overlaps the miss head is granted instead, whatever its age.
- R5: When both heads are ready and the write-back buffer is full with none in service, the write-back head is granted. The exception is a valid miss candidate that overlaps it with a strictly smaller order tag; that miss candidate is granted instead.
- R6: With neither head ready, a prefetch request is granted (`gnt_src`=3, `gnt_idx`=0) only when the miss queue is not full. Otherwise no grant is made.
- R7: While `rsp_pend` is high, no new grant is made from IDLE.
- R8: While `gnt_vld` is high and the bus neither accepts nor refuses, the grant stays valid and unchanged, even if the queue inputs change.
- R9: A refusal (`bus_nak`) drops `gnt_vld` on the next clock with no in-service notice. The grant is offered again, unchanged, one clock after `bus_retry`.
- R10: An acceptance (`bus_ack`) produces, one clock later, a single-cycle `svc_vld` carrying the accepted source and index. `gnt_vld` drops at the same time.
- R11: Two ranges [addr, addr+size) overlap when they share any cache line (line size 2^LSH bytes, 64 by default). Disjoint bytes in one line overlap; ranges in adjacent lines do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_pend | input | 1 | A response is ready to use the port |
| miss_vld | input | 1 | Miss queue head is ready |
| miss_idx | input | IDXW | Miss head entry index |
| miss_addr | input | AW | Miss head byte address |
| miss_size | input | SZW | Miss head byte count (at least 1) |
| miss_full | input | 1 | Miss queue has no free slot |
| wb_vld | input | 1 | Write-back head is ready |
| wb_idx | input | IDXW | Write-back head entry index |
| wb_addr | input | AW | Write-back head byte address |
| wb_size | input | SZW | Write-back head byte count |
| wb_order | input | OW | Write-back head age tag |
| wb_full | input | 1 | Write-back buffer is full |
| wb_busy | input | CNTW | Write-back entries in service |
| mcand_vld | input | 1 | Pending miss candidate exists |
| mcand_idx | input | IDXW | Miss candidate index |
| mcand_addr | input | AW | Miss candidate address |
| mcand_size | input | SZW | Miss candidate byte count |
| mcand_order | input | OW | Miss candidate age tag |
| wcand_vld | input | 1 | Pending write-back candidate exists |
| wcand_idx | input | IDXW | Write-back candidate index |
| wcand_addr | input | AW | Write-back candidate address |
| wcand_size | input | SZW | Write-back candidate byte count |
| pf_vld | input | 1 | Prefetch request available |
| bus_ack | input | 1 | Bus accepts the offered grant |
| bus_nak | input | 1 | Bus refuses the offered grant |
| bus_retry | input | 1 | Bus invites a refused grant again |
| gnt_vld | output | 1 | Grant offered to the bus |
| gnt_src | output | 2 | Granted source (1 miss, 2 write-back, 3 prefetch) |
| gnt_idx | output | IDXW | Granted entry index |
| svc_vld | output | 1 | Accepted entry may be marked in service |
| svc_src | output | 2 | Source of the accepted entry |
| svc_idx | output | IDXW | Index of the accepted entry |

## Verification
A corrupted state register shows up within one clock. It appears as a grant driven while the bus was told to retry, or as a grant that vanishes without acknowledge or refusal. A wrong captured grant appears as a different source or index on `gnt_src`/`gnt_idx` in the cycle after the inputs. It appears again in the in-service notice one clock after acceptance. An error in the overlap or age comparison is only visible when both queues are ready. For that reason the directed cases place ranges in the same line, in adjacent lines, and with older, equal and newer tags.

// File: rtl/memreq_pkg.sv
`timescale 1ns/1ps
package memreq_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MISS = 2'd1,
        SRC_WB   = 2'd2,
        SRC_PF   = 2'd3
    } src_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HOLD  = 2'd2
    } arb_st_t;
endpackage

// File: rtl/memreq_overlap.sv
`timescale 1ns/1ps
module memreq_overlap #(
    parameter int AW  = 32,
    parameter int SZW = 8,
    parameter int LSH = 6
) (
    input  logic [AW-1:0]  a_addr,
    input  logic [SZW-1:0] a_size,
    input  logic [AW-1:0]  b_addr,
    input  logic [SZW-1:0] b_size,
    output logic           hit
);
    localparam int LW = AW - LSH;

    logic [AW-1:0] a_end, b_end;
    logic [LW-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_end = a_addr + AW'(a_size) - AW'(1);
        b_end = b_addr + AW'(b_size) - AW'(1);
        a_lo  = LW'(a_addr >> LSH);
        a_hi  = LW'(a_end  >> LSH);
        b_lo  = LW'(b_addr >> LSH);
        b_hi  = LW'(b_end  >> LSH);
        hit   = (a_lo <= b_hi) && (b_lo <= a_hi);
    end
endmodule

// File: rtl/memreq_select.sv
`timescale 1ns/1ps
module memreq_select
    import memreq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SZW  = 8,
    parameter int IDXW = 3,
    parameter int OW   = 8,
    parameter int CNTW = 3,
    parameter int LSH  = 6
) (
    input  logic            miss_vld,
    input  logic [IDXW-1:0] miss_idx,
    input  logic [AW-1:0]   miss_addr,
    input  logic [SZW-1:0]  miss_size,
    input  logic            miss_full,
    input  logic            wb_vld,
    input  logic [IDXW-1:0] wb_idx,
    input  logic [AW-1:0]   wb_addr,
    input  logic [SZW-1:0]  wb_size,
    input  logic [OW-1:0]   wb_order,
    input  logic            wb_full,
    input  logic [CNTW-1:0] wb_busy,
    input  logic            mcand_vld,
    input  logic [IDXW-1:0] mcand_idx,
    input  logic [AW-1:0]   mcand_addr,
    input  logic [SZW-1:0]  mcand_size,
    input  logic [OW-1:0]   mcand_order,
    input  logic            wcand_vld,
    input  logic [IDXW-1:0] wcand_idx,
    input  logic [AW-1:0]   wcand_addr,
    input  logic [SZW-1:0]  wcand_size,
    input  logic            pf_vld,
    output src_t            pick_src,
    output logic [IDXW-1:0] pick_idx
);
    logic mc_hit;   // miss candidate vs write-back head
    logic wc_hit;   // write-back candidate vs miss head
    logic wr_favor;

    memreq_overlap #(.AW(AW), .SZW(SZW), .LSH(LSH)) u_mc_ovl (
        .a_addr (mcand_addr),
        .a_size (mcand_size),
        .b_addr (wb_addr),
        .b_size (wb_size),
        .hit    (mc_hit)
    );

    memreq_overlap #(.AW(AW), .SZW(SZW), .LSH(LSH)) u_wc_ovl (
        .a_addr (wcand_addr),
        .a_size (wcand_size),
        .b_addr (miss_addr),
        .b_size (miss_size),
        .hit    (wc_hit)
    );

    always_comb begin
        wr_favor = wb_full && (wb_busy == '0);
        pick_src = SRC_NONE;
        pick_idx = '0;
        if (miss_vld && wb_vld) begin
            if (wr_favor) begin
                if (mcand_vld && mc_hit && (mcand_order < wb_order)) begin
                    pick_src = SRC_MISS;
                    pick_idx = mcand_idx;
                end else begin
                    pick_src = SRC_WB;
                    pick_idx = wb_idx;
                end
            end else if (wcand_vld && wc_hit) begin
                pick_src = SRC_WB;
                pick_idx = wcand_idx;
            end else begin
                pick_src = SRC_MISS;
                pick_idx = miss_idx;
            end
        end else if (miss_vld) begin
            pick_src = SRC_MISS;
            pick_idx = miss_idx;
        end else if (wb_vld) begin
            pick_src = SRC_WB;
            pick_idx = wb_idx;
        end else if (pf_vld && !miss_full) begin
            pick_src = SRC_PF;
            pick_idx = '0;
        end
    end
endmodule

// File: rtl/memreq_arbiter.sv
`timescale 1ns/1ps
module memreq_arbiter
    import memreq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SZW  = 8,
    parameter int IDXW = 3,
    parameter int OW   = 8,
    parameter int CNTW = 3,
    parameter int LSH  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rsp_pend,
    input  logic            miss_vld,
    input  logic [IDXW-1:0] miss_idx,
    input  logic [AW-1:0]   miss_addr,
    input  logic [SZW-1:0]  miss_size,
    input  logic            miss_full,
    input  logic            wb_vld,
    input  logic [IDXW-1:0] wb_idx,
    input  logic [AW-1:0]   wb_addr,
    input  logic [SZW-1:0]  wb_size,
    input  logic [OW-1:0]   wb_order,
    input  logic            wb_full,
    input  logic [CNTW-1:0] wb_busy,
    input  logic            mcand_vld,
    input  logic [IDXW-1:0] mcand_idx,
    input  logic [AW-1:0]   mcand_addr,
    input  logic [SZW-1:0]  mcand_size,
    input  logic [OW-1:0]   mcand_order,
    input  logic            wcand_vld,
    input  logic [IDXW-1:0] wcand_idx,
    input  logic [AW-1:0]   wcand_addr,
    input  logic [SZW-1:0]  wcand_size,
    input  logic            pf_vld,
    input  logic            bus_ack,
    input  logic            bus_nak,
    input  logic            bus_retry,
    output logic            gnt_vld,
    output logic [1:0]      gnt_src,
    output logic [IDXW-1:0] gnt_idx,
    output logic            svc_vld,
    output logic [1:0]      svc_src,
    output logic [IDXW-1:0] svc_idx
);
    src_t            pick_src;
    logic [IDXW-1:0] pick_idx;
    arb_st_t         state, nxt;
    logic            take;

    src_t            g_src_q;
    logic [IDXW-1:0] g_idx_q;
    logic            s_vld_q;
    src_t            s_src_q;
    logic [IDXW-1:0] s_idx_q;

    memreq_select #(
        .AW(AW), .SZW(SZW), .IDXW(IDXW), .OW(OW), .CNTW(CNTW), .LSH(LSH)
    ) u_sel (
        .miss_vld    (miss_vld),
        .miss_idx    (miss_idx),
        .miss_addr   (miss_addr),
        .miss_size   (miss_size),
        .miss_full   (miss_full),
        .wb_vld      (wb_vld),
        .wb_idx      (wb_idx),
        .wb_addr     (wb_addr),
        .wb_size     (wb_size),
        .wb_order    (wb_order),
        .wb_full     (wb_full),
        .wb_busy     (wb_busy),
        .mcand_vld   (mcand_vld),
        .mcand_idx   (mcand_idx),
        .mcand_addr  (mcand_addr),
        .mcand_size  (mcand_size),
        .mcand_order (mcand_order),
        .wcand_vld   (wcand_vld),
        .wcand_idx   (wcand_idx),
        .wcand_addr  (wcand_addr),
        .wcand_size  (wcand_size),
        .pf_vld      (pf_vld),
        .pick_src    (pick_src),
        .pick_idx    (pick_idx)
    );

    assign take = !rsp_pend && (pick_src != SRC_NONE);

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (take) nxt = ST_OFFER;
            ST_OFFER: begin
                if (bus_ack)      nxt = ST_IDLE;
                else if (bus_nak) nxt = ST_HOLD;
            end
            ST_HOLD:  if (bus_retry) nxt = ST_OFFER;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_src_q <= SRC_NONE;
            g_idx_q <= '0;
            s_vld_q <= 1'b0;
            s_src_q <= SRC_NONE;
            s_idx_q <= '0;
        end else begin
            s_vld_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        g_src_q <= pick_src;
                        g_idx_q <= pick_idx;
                    end
                end
                ST_OFFER: begin
                    if (bus_ack) begin
                        s_vld_q <= 1'b1;
                        s_src_q <= g_src_q;
                        s_idx_q <= g_idx_q;
                    end
                end
                ST_HOLD: ;
                default: ;
            endcase
        end
    end

    assign gnt_vld = (state == ST_OFFER);
    assign gnt_src = g_src_q;
    assign gnt_idx = g_idx_q;
    assign svc_vld = s_vld_q;
    assign svc_src = s_src_q;
    assign svc_idx = s_idx_q;

    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld && !bus_ack && !bus_nak |=> gnt_vld && $stable(gnt_src) && $stable(gnt_idx));

    // R9
    nak_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld && bus_nak && !bus_ack |=> !gnt_vld && !svc_vld && $stable(gnt_idx) && $stable(gnt_src));

    // R10
    svc_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld && bus_ack |=> svc_vld && !gnt_vld && svc_idx == $past(gnt_idx) && svc_src == $past(gnt_src));

    // R10
    svc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_vld |-> $past(gnt_vld && bus_ack));

    // R7
    rsp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && rsp_pend |=> !gnt_vld);

    // R6
    pf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld && $past(state == ST_IDLE) && gnt_src == SRC_PF |-> $past(!miss_full && !miss_vld && !wb_vld));
endmodule

// File: tb/memreq_arbiter_test.sv
`timescale 1ns/1ps
module memreq_arbiter_test;
    localparam int AW = 32, SZW = 8, IDXW = 3, OW = 8, CNTW = 3, LSH = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, rsp_pend = 1'b0;
    logic miss_vld = 0, miss_full = 0, wb_vld = 0, wb_full = 0;
    logic [IDXW-1:0] miss_idx = '0, wb_idx = '0, mcand_idx = '0, wcand_idx = '0;
    logic [AW-1:0] miss_addr = '0, wb_addr = '0, mcand_addr = '0, wcand_addr = '0;
    logic [SZW-1:0] miss_size = 8'd1, wb_size = 8'd1, mcand_size = 8'd1, wcand_size = 8'd1;
    logic [OW-1:0] wb_order = '0, mcand_order = '0;
    logic [CNTW-1:0] wb_busy = '0;
    logic mcand_vld = 0, wcand_vld = 0, pf_vld = 0;
    logic bus_ack = 0, bus_nak = 0, bus_retry = 0;
    logic gnt_vld, svc_vld;
    logic [1:0] gnt_src, svc_src;
    logic [IDXW-1:0] gnt_idx, svc_idx;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    memreq_arbiter #(.AW(AW), .SZW(SZW), .IDXW(IDXW), .OW(OW), .CNTW(CNTW), .LSH(LSH)) uut (
        .clk(clk), .rst_n(rst_n), .rsp_pend(rsp_pend),
        .miss_vld(miss_vld), .miss_idx(miss_idx), .miss_addr(miss_addr),
        .miss_size(miss_size), .miss_full(miss_full),
        .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_addr(wb_addr), .wb_size(wb_size),
        .wb_order(wb_order), .wb_full(wb_full), .wb_busy(wb_busy),
        .mcand_vld(mcand_vld), .mcand_idx(mcand_idx), .mcand_addr(mcand_addr),
        .mcand_size(mcand_size), .mcand_order(mcand_order),
        .wcand_vld(wcand_vld), .wcand_idx(wcand_idx), .wcand_addr(wcand_addr),
        .wcand_size(wcand_size), .pf_vld(pf_vld),
        .bus_ack(bus_ack), .bus_nak(bus_nak), .bus_retry(bus_retry),
        .gnt_vld(gnt_vld), .gnt_src(gnt_src), .gnt_idx(gnt_idx),
        .svc_vld(svc_vld), .svc_src(svc_src), .svc_idx(svc_idx)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_q();
        miss_vld = 0; wb_vld = 0; mcand_vld = 0; wcand_vld = 0; pf_vld = 0;
        miss_full = 0; wb_full = 0; wb_busy = '0;
    endtask

    // grant expected one clock after inputs; then accept and check the notice
    task automatic see_grant(string req, int src, int idx);
        @(posedge clk); #1;
        check(req, "gnt_vld", int'(gnt_vld), 1);
        check(req, "gnt_src", int'(gnt_src), src);
        check(req, "gnt_idx", int'(gnt_idx), idx);
        @(negedge clk);
        bus_ack = 1;
        clear_q();
        @(posedge clk); #1;
        check("R10", "svc_vld", int'(svc_vld), 1);
        check("R10", "svc src/idx", int'({svc_src, svc_idx}), (src << IDXW) | idx);
        check("R10", "gnt_vld after ack", int'(gnt_vld), 0);
        @(negedge clk);
        bus_ack = 0;
    endtask

    task automatic see_none(string req, int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            check(req, "gnt_vld", int'(gnt_vld), 0);
        end
        @(negedge clk);
        clear_q();
    endtask

    task automatic t_reset();
        repeat (2) @(posedge clk);
        #1;
        check("R1", "gnt_vld in reset", int'(gnt_vld), 0);
        check("R1", "svc_vld in reset", int'(svc_vld), 0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        check("R1", "gnt_vld after reset", int'(gnt_vld), 0);
    endtask

    task automatic t_single();
        @(negedge clk);
        miss_vld = 1; miss_idx = 3; miss_addr = 32'h100; miss_size = 8;
        see_grant("R2", 1, 3);
        wb_vld = 1; wb_idx = 5; wb_addr = 32'h200; wb_size = 64;
        see_grant("R2", 2, 5);
    endtask

    task automatic t_miss_favored();
        // no candidate, buffer not full
        miss_vld = 1; miss_idx = 1; miss_addr = 32'h1000; miss_size = 8;
        wb_vld = 1; wb_idx = 4; wb_addr = 32'h3000; wb_size = 64;
        see_grant("R3", 1, 1);
        // full but one in service: still miss
        miss_vld = 1; miss_idx = 2; miss_addr = 32'h1000; miss_size = 8;
        wb_vld = 1; wb_idx = 4; wb_addr = 32'h3000; wb_size = 64;
        wb_full = 1; wb_busy = 1;
        see_grant("R3", 1, 2);
        // candidate in the adjacent line: no overlap
        miss_vld = 1; miss_idx = 1; miss_addr = 32'h1000; miss_size = 8;
        wb_vld = 1; wb_idx = 4; wb_addr = 32'h3000; wb_size = 64;
        wcand_vld = 1; wcand_idx = 6; wcand_addr = 32'h1040; wcand_size = 8;
        see_grant("R11", 1, 1);
        // candidate in the same line, disjoint bytes: overlap wins
        miss_vld = 1; miss_idx = 1; miss_addr = 32'h1000; miss_size = 8;
        wb_vld = 1; wb_idx = 4; wb_addr = 32'h3000; wb_size = 64;
        wcand_vld = 1; wcand_idx = 6; wcand_addr = 32'h1020; wcand_size = 8;
        see_grant("R4", 2, 6);
    endtask

    task automatic t_write_favored();
        miss_vld = 1; miss_idx = 1; miss_addr = 32'h1000; miss_size = 8;
        wb_vld = 1; wb_idx = 4; wb_addr = 32'h2000; wb_size = 64; wb_order = 7;
        wb_full = 1; wb_busy = 0;
        see_grant("R5", 2, 4);
        // older overlapping miss candidate goes first
        miss_vld = 1; miss_idx = 1; miss_addr = 32'h1000; miss_size = 8;
        wb_vld = 1; wb_idx = 4; wb_addr = 32'h2000; wb_size = 64; wb_order = 7;
        wb_full = 1; mcand_vld = 1; mcand_idx = 5;
        mcand_addr = 32'h2010; mcand_size = 4; mcand_order = 3;
        see_grant("R5", 1, 5);
        // equal tag is not older
        miss_vld = 1; miss_idx = 1; miss_addr = 32'h1000; miss_size = 8;
        wb_vld = 1; wb_idx = 4; wb_addr = 32'h2000; wb_size = 64; wb_order = 7;
        wb_full = 1; mcand_vld = 1; mcand_idx = 5;
        mcand_addr = 32'h2010; mcand_size = 4; mcand_order = 7;
        see_grant("R5", 2, 4);
        // older but not overlapping (adjacent line)
        miss_vld = 1; miss_idx = 1; miss_addr = 32'h1000; miss_size = 8;
        wb_vld = 1; wb_idx = 4; wb_addr = 32'h2000; wb_size = 64; wb_order = 7;
        wb_full = 1; mcand_vld = 1; mcand_idx = 5;
        mcand_addr = 32'h2040; mcand_size = 4; mcand_order = 1;
        see_grant("R11", 2, 4);
    endtask

    task automatic t_prefetch();
        pf_vld = 1;
        see_grant("R6", 3, 0);
        pf_vld = 1; miss_full = 1;
        see_none("R6", 3);
    endtask

    task automatic t_rsp();
        rsp_pend = 1; miss_vld = 1; miss_idx = 7; miss_addr = 32'h40; miss_size = 4;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            check("R7", "gnt_vld under response", int'(gnt_vld), 0);
        end
        @(negedge clk);
        rsp_pend = 0;
        see_grant("R7", 1, 7);
    endtask

    task automatic t_refuse();
        miss_vld = 1; miss_idx = 2; miss_addr = 32'h80; miss_size = 4;
        @(posedge clk); #1;
        check("R8", "gnt_idx", int'(gnt_idx), 2);
        @(negedge clk);
        miss_idx = 6; wb_vld = 1; wb_idx = 1;
        @(posedge clk); #1;
        check("R8", "gnt held vld", int'(gnt_vld), 1);
        check("R8", "gnt held idx", int'({gnt_src, gnt_idx}), (1 << IDXW) | 2);
        @(negedge clk);
        bus_nak = 1;
        @(posedge clk); #1;
        check("R9", "gnt_vld after nak", int'(gnt_vld), 0);
        check("R9", "svc_vld after nak", int'(svc_vld), 0);
        @(negedge clk);
        bus_nak = 0;
        @(posedge clk); #1;
        check("R9", "gnt_vld while waiting", int'(gnt_vld), 0);
        @(negedge clk);
        bus_retry = 1;
        @(posedge clk); #1;
        check("R9", "gnt_vld after retry", int'(gnt_vld), 1);
        check("R9", "gnt after retry", int'({gnt_src, gnt_idx}), (1 << IDXW) | 2);
        @(negedge clk);
        bus_retry = 0; bus_ack = 1; clear_q();
        @(posedge clk); #1;
        check("R10", "svc after retry", int'({svc_vld, svc_src, svc_idx}), (1 << (IDXW + 2)) | (1 << IDXW) | 2);
        @(negedge clk);
        bus_ack = 0;
        @(posedge clk); #1;
        check("R10", "svc single pulse", int'(svc_vld), 0);
    endtask

    initial begin
        t_reset();
        t_single();
        @(negedge clk); t_miss_favored();
        @(negedge clk); t_write_favored();
        @(negedge clk); t_prefetch();
        @(negedge clk); t_rsp();
        @(negedge clk); t_refuse();
        repeat (3) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule